// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block gives the fetch stage its next program counter. Fetch presents the current PC. Low PC bits select one slot of a direct-mapped table. That slot holds a valid flag, the complete address of a control-transfer instruction and the address it last went to. When the slot is valid and its stored address equals the fetch PC, the block reports a hit and returns the stored destination. Otherwise it returns the next sequential instruction address, the fetch PC plus four. Because the full branch address is kept as the tag, two PCs that share an index can never be confused.

Entries change only through a resolution port, which is driven after a branch or jump has executed. A taken outcome writes the slot, replacing whatever was there. A not-taken outcome for an address that is resident removes it. The table therefore holds only control transfers that were taken last time, and a miss always means sequential fetch. A write lands on the clock edge, so a lookup in the same cycle still sees the old slot contents. A synchronous reset empties the table.

Top module: `btb_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) every slot is empty, so every lookup reports `fetch_hit` = 0.
- R2: A hit requires the slot's valid flag and a stored branch address equal to all bits of `fetch_pc`. A PC that shares the slot but differs in higher bits misses.
- R3: On a hit, `fetch_hit` = 1 and `next_pc` equals the destination stored in the slot.
- R4: On a miss, `fetch_hit` = 0 and `next_pc` = `fetch_pc` + 4, modulo 2^32 (0xFFFFFFFC yields 0x00000000).
- R5: A resolution with `upd_valid` = 1 and `upd_taken` = 1 writes {valid, `upd_pc`, `upd_target`} into the slot at the clock edge. A lookup in that same cycle sees the old contents. A lookup in the following cycle hits.
- R6: A taken resolution overwrites the indexed slot whatever it holds. This evicts a different branch that shares the slot, or replaces the destination of the same branch.
- R7: A resolution with `upd_valid` = 1 and `upd_taken` = 0 whose address matches a valid resident slot clears that slot, so the address misses afterwards.
- R8: A not-taken resolution whose address does not match the slot's stored address leaves the slot unchanged.
- R9: While `upd_valid` = 0, the table does not change, whatever the other resolution inputs carry.
- R10: The slot index is `fetch_pc`[IDX_W+1:2] (and `upd_pc`[IDX_W+1:2] for writes), 16 slots by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, empties the table |
| fetch_pc | input | 32 | PC currently being fetched |
| fetch_hit | output | 1 | High when the fetch PC is resident (redirect) |
| next_pc | output | 32 | Predicted next fetch PC |
| upd_valid | input | 1 | A branch resolution is presented this cycle |
| upd_taken | input | 1 | Resolved outcome: 1 taken, 0 not taken |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved destination, used when taken |

## Verification
The lookup is tried with a PC that was just allocated, with an alias that shares the slot but not the upper bits, with a neighbouring slot, and with the top of the address space. Together these separate a true tag match from an index-only match, and a redirect from sequential fetch including wrap-around. Resolution is tried as a taken allocation, an eviction by a conflicting branch, a destination change, a not-taken resolution with a matching tag and one with a foreign tag, and inputs that toggle while `upd_valid` is low. These separate invalidation from blind clearing and show that the write becomes visible only after the edge.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PC_W        = 32;
    localparam int INSTR_BYTES = 4;
    localparam int OFS_W       = $clog2(INSTR_BYTES);

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        logic valid;
        pc_t  tag;
        pc_t  target;
    } btb_entry_t;

    typedef struct packed {
        logic valid;
        logic taken;
        pc_t  pc;
        pc_t  target;
    } btb_resolve_t;

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(INSTR_BYTES);
    endfunction

    function automatic pc_t word_addr(input pc_t pc);
        return pc >> OFS_W;
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output btb_entry_t       rd_entry,
    input  logic [IDX_W-1:0] chk_idx,
    output btb_entry_t       chk_entry,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  btb_entry_t       wr_entry
);
    localparam int DEPTH = 1 << IDX_W;

    btb_entry_t slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i].valid <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                slots[i] <= wr_entry;
            end
        end

        AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(slots[i])) // R9
            else $error("slot %0d changed without a write", i);
    end

    always_comb begin
        rd_entry  = slots[rd_idx];
        chk_entry = slots[chk_idx];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slots[$past(wr_idx)] == $past(wr_entry)) // R5
        else $error("write did not land");

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  pc_t              fetch_pc,
    output logic [IDX_W-1:0] rd_idx,
    input  btb_entry_t       rd_entry,
    output logic             hit,
    output pc_t              next_pc
);
    pc_t word;

    always_comb begin
        word    = word_addr(fetch_pc);
        rd_idx  = word[IDX_W-1:0];
        hit     = rd_entry.valid && (rd_entry.tag == fetch_pc);
        next_pc = hit ? rd_entry.target : seq_pc(fetch_pc);
    end

    AST_MISS_SEQ: assert property (@(posedge clk) disable iff (rst)
        !hit |-> next_pc == fetch_pc + 32'd4) // R4
        else $error("miss without sequential pc");

endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  btb_resolve_t     res,
    output logic [IDX_W-1:0] chk_idx,
    input  btb_entry_t       chk_entry,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output btb_entry_t       wr_entry
);
    pc_t  word;
    logic resident;

    always_comb begin
        word     = word_addr(res.pc);
        chk_idx  = word[IDX_W-1:0];
        wr_idx   = chk_idx;
        resident = chk_entry.valid && (chk_entry.tag == res.pc);
        wr_en    = res.valid && (res.taken || resident);
        wr_entry = '{valid: res.taken, tag: res.pc, target: res.target};
    end

endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    output logic        fetch_hit,
    output logic [31:0] next_pc,
    input  logic        upd_valid,
    input  logic        upd_taken,
    input  logic [31:0] upd_pc,
    input  logic [31:0] upd_target
);
    logic [IDX_W-1:0] rd_idx, chk_idx, wr_idx;
    btb_entry_t       rd_entry, chk_entry, wr_entry;
    logic             wr_en;
    btb_resolve_t     res;

    assign res = '{valid: upd_valid, taken: upd_taken, pc: upd_pc, target: upd_target};

    btb_store #(.IDX_W(IDX_W)) store_i (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .chk_idx(chk_idx), .chk_entry(chk_entry),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry)
    );

    btb_lookup #(.IDX_W(IDX_W)) lookup_i (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .hit(fetch_hit), .next_pc(next_pc)
    );

    btb_update #(.IDX_W(IDX_W)) update_i (
        .res(res), .chk_idx(chk_idx), .chk_entry(chk_entry),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !fetch_hit) // R1
        else $error("hit right after reset");

    AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |=>
            (fetch_pc != $past(upd_pc) || (fetch_hit && next_pc == $past(upd_target)))) // R5
        else $error("allocated branch not visible");

    AST_INVAL_MISS: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken) |=> (fetch_pc != $past(upd_pc) || !fetch_hit)) // R7
        else $error("not-taken branch still resident");

endmodule

// File: tb/btb_top_tb.sv
module btb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        fetch_hit;
    logic [31:0] next_pc;
    logic        upd_valid = 1'b0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    btb_top dut_i (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
        .next_pc(next_pc), .upd_valid(upd_valid), .upd_taken(upd_taken),
        .upd_pc(upd_pc), .upd_target(upd_target)
    );

    typedef struct packed {
        logic        uv;
        logic        ut;
        logic [31:0] upc;
        logic [31:0] utgt;
        logic [31:0] fpc;
        logic        ehit;
        logic [31:0] enext;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 32'h1004, 32'h2000, 32'h1004, 1'b1, 32'h2000, 8'd5},  // R5 R3 allocate
        '{1'b0, 1'b1, 32'h1044, 32'h3000, 32'h1044, 1'b0, 32'h1048, 8'd9},  // R9 idle update
        '{1'b0, 1'b0, 32'h1004, 32'h0,    32'h1004, 1'b1, 32'h2000, 8'd9},  // R9 not cleared
        '{1'b0, 1'b0, 32'h0,    32'h0,    32'h1044, 1'b0, 32'h1048, 8'd2},  // R2 alias misses
        '{1'b1, 1'b1, 32'h1044, 32'h3000, 32'h1044, 1'b1, 32'h3000, 8'd6},  // R6 conflict write
        '{1'b0, 1'b0, 32'h0,    32'h0,    32'h1004, 1'b0, 32'h1008, 8'd6},  // R6 evicted
        '{1'b1, 1'b0, 32'h1004, 32'h0,    32'h1044, 1'b1, 32'h3000, 8'd8},  // R8 foreign tag
        '{1'b1, 1'b0, 32'h1044, 32'h0,    32'h1044, 1'b0, 32'h1048, 8'd7},  // R7 invalidate
        '{1'b1, 1'b1, 32'h003C, 32'h0100, 32'h003C, 1'b1, 32'h0100, 8'd10}, // R10 slot 15
        '{1'b0, 1'b0, 32'h0,    32'h0,    32'h0038, 1'b0, 32'h003C, 8'd10}, // R10 slot 14 empty
        '{1'b1, 1'b1, 32'hFFFFFFFC, 32'h0040, 32'hFFFFFFFC, 1'b1, 32'h0040, 8'd6}, // R6 evict slot 15
        '{1'b0, 1'b0, 32'h0,    32'h0,    32'h003C, 1'b0, 32'h0040, 8'd6},  // R6 old owner gone
        '{1'b1, 1'b0, 32'hFFFFFFFC, 32'h0, 32'hFFFFFFFC, 1'b0, 32'h00000000, 8'd4}, // R4 wrap
        '{1'b1, 1'b1, 32'h1004, 32'h2000, 32'h1004, 1'b1, 32'h2000, 8'd3},  // R3 reallocate
        '{1'b1, 1'b1, 32'h1004, 32'h2400, 32'h1004, 1'b1, 32'h2400, 8'd6}   // R6 new target
    };

    task automatic check(input logic ehit, input logic [31:0] enext, input int req);
        checks++;
        if (fetch_hit !== ehit || next_pc !== enext) begin
            failures++;
            $display("FAIL R%0d pc=%h actual hit=%b next=%h expected hit=%b next=%h",
                     req, fetch_pc, fetch_hit, next_pc, ehit, enext);
        end
    endtask

    task automatic resolve(input logic v, input logic t, input logic [31:0] pc,
                           input logic [31:0] tgt);
        @(negedge clk);
        upd_valid = v; upd_taken = t; upd_pc = pc; upd_target = tgt;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic probe(input logic [31:0] pc, input logic ehit,
                         input logic [31:0] enext, input int req);
        fetch_pc = pc;
        #1;
        check(ehit, enext, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        probe(32'h1004, 1'b0, 32'h1008, 1);  // R1 empty after reset

        for (int i = 0; i < NV; i++) begin
            resolve(VECS[i].uv, VECS[i].ut, VECS[i].upc, VECS[i].utgt);
            probe(VECS[i].fpc, VECS[i].ehit, VECS[i].enext, int'(VECS[i].req));
        end

        // R5: same-cycle lookup sees old contents, next cycle sees the write
        @(negedge clk);
        upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = 32'h0800; upd_target = 32'h0900;
        probe(32'h0800, 1'b0, 32'h0804, 5);
        @(posedge clk);
        #1 upd_valid = 1'b0;
        probe(32'h0800, 1'b1, 32'h0900, 5);

        // R1: reset empties populated slots
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        probe(32'h0800, 1'b0, 32'h0804, 1);
        probe(32'h1004, 1'b0, 32'h1008, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule